// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, one request at a time, whether a physical memory access may proceed. A request carries a byte start address, a byte count, a one-hot read, write or execute request and the current privilege mode. The block compares the access against a bank of protection entries and returns a grant or a deny. It also returns the complete read/write/execute set that the deciding rule allows, so that an address translation cache can keep that set as the permissions of a cached page.

The entries come in on input ports. Each entry has one configuration byte and one address register. Software state, register writes and page-table walking stay outside the block. A request that is valid at a rising clock edge gets its answer on the outputs during the next cycle, together with a response valid.

Top module: `pmpc_checker`

## Requirements
- R1: While reset is asserted, and for the first cycle after it, rsp_valid, rsp_grant, rsp_deny, rsp_r, rsp_w and rsp_x are all 0.
- R2: A request sampled with req_valid=1 at a clock edge produces rsp_valid=1 during the following cycle. After an edge with req_valid=0, every response output is 0.
- R3: Entries are checked from index 0 upward. The lowest-indexed entry that the access touches decides the result, and every higher index is ignored.
- R4: An entry covers an access only if both the first byte (req_addr) and the last byte (req_addr + size - 1) lie inside its region. A req_size of 0 counts as one byte.
- R5: Configuration byte fields are R at bit 0, W at bit 1, X at bit 2, match mode at bits 4:3, and lock at bit 7. An entry whose match mode is 0 (off) never matches, whatever its address register holds.
- R6: Match mode 1 is a top-of-range region, [prev*4, this*4). Here prev is the previous entry's address register, and it is 0 for entry 0. The region is empty when its top is not above its base.
- R7: Match mode 2 is a naturally aligned 4-byte region starting at the address register times 4.
- R8: Match mode 3 is a naturally aligned power-of-two region. If the address register ends in t one bits, the region holds 2^(t+3) bytes and is aligned to that size.
- R9: On a covering entry, machine mode (mode code 3) is allowed R, W and X unless the lock bit of that entry is set. A locked entry, or any other mode (codes 0 and 1), is allowed only the entry's R/W/X bits.
- R10: rsp_grant=1 exactly when every requested bit of req_rwx (bit 0 read, bit 1 write, bit 2 execute) is in the allowed set. rsp_deny is its complement on a valid response. rsp_r, rsp_w and rsp_x carry the allowed set.
- R11: When no entry touches the access, machine mode is granted with R, W and X all set. Any other mode is denied with an empty allowed set.
- R12: If the deciding entry is touched but does not cover the access, the access is denied in every mode, with an empty allowed set. Lower-priority entries are not consulted.
- R13: With the PROT_EN parameter at 0, every request is granted with R, W and X all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address of the first byte |
| req_size | input | SZW | Byte count (0 treated as 1) |
| req_rwx | input | 3 | One-hot request: bit 0 read, bit 1 write, bit 2 execute |
| req_mode | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| ent_cfg | input | NE*8 | Configuration byte of entry i at bits [8i+7:8i] |
| ent_addr | input | NE*(AW-2) | Address register of entry i (byte address / 4) |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_deny | output | 1 | Access refused |
| rsp_r | output | 1 | Allowed set: read |
| rsp_w | output | 1 | Allowed set: write |
| rsp_x | output | 1 | Allowed set: execute |

## Verification
The decision goes straight from the request and configuration into one output register, so any fault in the region bounds, the priority scan or the default rule shows on the grant and permission bits in the very next cycle. The reference model computes regions from integer arithmetic and compares every cycle. A wrong bound is exposed by accesses that straddle region edges, and a wrong scan order by overlapping entries with different permissions. A lock, mode or partial-overlap fault appears as one wrong grant bit or one wrong permission bit on a single response.

// File: rtl/pmpc_pkg.sv
// Package: shared encodings for the protection checker.
// Assumes the configuration byte layout listed in the brief.
package pmpc_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsv;
        amode_e     amode;
        logic       x;
        logic       w;
        logic       r;
    } ecfg_t;

    localparam logic [1:0] PRIV_M = 2'b11;

endpackage

// File: rtl/pmpc_region.sv
// Region decoder: turns one entry's match mode and address register into an
// inclusive byte range [lo, hi] plus an enable. Assumes prev_reg is the
// previous entry's address register (zero for entry 0).
module pmpc_region
    import pmpc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  amode_e        amode,
    input  logic [AW-3:0] addr_reg,
    input  logic [AW-3:0] prev_reg,
    output logic          rgn_en,
    output logic [AW-1:0] rgn_lo,
    output logic [AW-1:0] rgn_hi
);
    localparam int ARW = AW - 2;

    logic [ARW-1:0] napot_mask;
    logic [AW-1:0]  tor_base;
    logic [AW-1:0]  tor_top;

    // Mask of the trailing ones plus the first zero above them.
    assign napot_mask = addr_reg ^ (addr_reg + ARW'(1));
    assign tor_base   = {prev_reg, 2'b00};
    assign tor_top    = {addr_reg, 2'b00};

    // Select the range bounds for the configured match mode.
    always_comb begin
        rgn_en = 1'b0;
        rgn_lo = '0;
        rgn_hi = '0;
        unique case (amode)
            AM_OFF: begin
                rgn_en = 1'b0;
            end
            AM_TOR: begin
                rgn_en = tor_top > tor_base;
                rgn_lo = tor_base;
                rgn_hi = tor_top - AW'(1);
            end
            AM_NA4: begin
                rgn_en = 1'b1;
                rgn_lo = {addr_reg, 2'b00};
                rgn_hi = {addr_reg, 2'b11};
            end
            AM_NAPOT: begin
                rgn_en = 1'b1;
                rgn_lo = {addr_reg & ~napot_mask, 2'b00};
                rgn_hi = {addr_reg | napot_mask, 2'b11};
            end
            default: rgn_en = 1'b0;
        endcase
    end

    // R7
    na4_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amode == AM_NA4) |-> (rgn_en && (rgn_hi - rgn_lo == AW'(3))));

    // R6
    tor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amode == AM_TOR && rgn_en) |-> (rgn_lo <= rgn_hi));

endmodule

// File: rtl/pmpc_match.sv
// Coverage test: compares one access [first, last] against one region and
// reports full coverage and any overlap. last is one bit wider than first,
// so an access that runs past the top of the address space never wraps.
module pmpc_match #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rgn_en,
    input  logic [AW-1:0] rgn_lo,
    input  logic [AW-1:0] rgn_hi,
    input  logic [AW-1:0] acc_first,
    input  logic [AW:0]   acc_last,
    output logic          full,
    output logic          touch
);
    // Both ends inside gives full coverage; any overlap counts as a touch.
    always_comb begin
        full  = rgn_en && (acc_first >= rgn_lo) && (acc_last <= {1'b0, rgn_hi});
        touch = rgn_en && (acc_first <= rgn_hi) && (acc_last >= {1'b0, rgn_lo});
    end

    // R4
    full_in_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> touch);

endmodule

// File: rtl/pmpc_select.sv
// Priority select: the lowest-index touched entry decides the result. A full
// cover yields that entry's permissions. A partial cover is a refusal with an
// empty set. No touch falls back to the privilege-mode default.
module pmpc_select
    import pmpc_pkg::*;
#(
    parameter int NE = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NE-1:0]   full_v,
    input  logic [NE-1:0]   touch_v,
    input  logic [NE-1:0]   lock_v,
    input  logic [NE*3-1:0] rwx_v,
    input  logic [1:0]      mode,
    output logic            ok_o,
    output logic [2:0]      allow_o
);
    logic found;

    // Scan from entry 0 upward and stop at the first touched entry.
    always_comb begin
        found   = 1'b0;
        ok_o    = 1'b0;
        allow_o = 3'b000;
        for (int i = 0; i < NE; i++) begin
            if (!found && touch_v[i]) begin
                found = 1'b1;
                if (full_v[i]) begin
                    ok_o    = 1'b1;
                    allow_o = (mode == PRIV_M && !lock_v[i]) ? 3'b111 : rwx_v[i*3 +: 3];
                end
            end
        end
        if (!found && mode == PRIV_M) begin
            ok_o    = 1'b1;
            allow_o = 3'b111;
        end
    end

    // R12
    partial_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|touch_v) && !(|full_v)) |-> (!ok_o && allow_o == 3'b000));

endmodule

// File: rtl/pmpc_checker.sv
// Top: registers one protection decision per valid request. Assumes the
// configuration ports are stable around the sampling edge. Latency is one
// cycle, from the request edge to the response outputs.
module pmpc_checker
    import pmpc_pkg::*;
#(
    parameter int NE      = 16,
    parameter int AW      = 32,
    parameter int SZW     = 4,
    parameter bit PROT_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [AW-1:0]          req_addr,
    input  logic [SZW-1:0]         req_size,
    input  logic [2:0]             req_rwx,
    input  logic [1:0]             req_mode,
    input  logic [NE*8-1:0]        ent_cfg,
    input  logic [NE*(AW-2)-1:0]   ent_addr,
    output logic                   rsp_valid,
    output logic                   rsp_grant,
    output logic                   rsp_deny,
    output logic                   rsp_r,
    output logic                   rsp_w,
    output logic                   rsp_x
);
    localparam int ARW = AW - 2;

    logic [SZW-1:0] eff_size;
    logic [AW:0]    acc_last;
    logic [2:0]     allow_c;
    logic           ok_c;
    logic           grant_c;

    // Last byte of the access; a zero count is taken as one byte.
    always_comb begin
        eff_size = (req_size == '0) ? SZW'(1) : req_size;
        acc_last = {1'b0, req_addr} + (AW+1)'(eff_size) - (AW+1)'(1);
    end

    generate
        if (PROT_EN) begin : g_prot
            ecfg_t [NE-1:0]  cfg_arr;
            logic [NE-1:0]   full_v;
            logic [NE-1:0]   touch_v;
            logic [NE-1:0]   lock_v;
            logic [NE*3-1:0] rwx_v;

            assign cfg_arr = ent_cfg;

            for (genvar i = 0; i < NE; i++) begin : g_ent
                logic [ARW-1:0] prev_reg;
                logic           rgn_en;
                logic [AW-1:0]  rgn_lo;
                logic [AW-1:0]  rgn_hi;
                logic [1:0]     unused_rsv;

                if (i == 0) begin : g_first
                    assign prev_reg = '0;
                end else begin : g_rest
                    assign prev_reg = ent_addr[(i-1)*ARW +: ARW];
                end

                assign unused_rsv       = cfg_arr[i].rsv;
                assign lock_v[i]        = cfg_arr[i].lock;
                assign rwx_v[i*3 +: 3]  = {cfg_arr[i].x, cfg_arr[i].w, cfg_arr[i].r};

                pmpc_region #(.AW(AW)) u_region (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .amode    (cfg_arr[i].amode),
                    .addr_reg (ent_addr[i*ARW +: ARW]),
                    .prev_reg (prev_reg),
                    .rgn_en   (rgn_en),
                    .rgn_lo   (rgn_lo),
                    .rgn_hi   (rgn_hi)
                );

                pmpc_match #(.AW(AW)) u_match (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .rgn_en    (rgn_en),
                    .rgn_lo    (rgn_lo),
                    .rgn_hi    (rgn_hi),
                    .acc_first (req_addr),
                    .acc_last  (acc_last),
                    .full      (full_v[i]),
                    .touch     (touch_v[i])
                );
            end

            pmpc_select #(.NE(NE)) u_select (
                .clk     (clk),
                .rst_n   (rst_n),
                .full_v  (full_v),
                .touch_v (touch_v),
                .lock_v  (lock_v),
                .rwx_v   (rwx_v),
                .mode    (req_mode),
                .ok_o    (ok_c),
                .allow_o (allow_c)
            );
        end else begin : g_open
            logic unused_open;
            assign unused_open = ^{ent_cfg, ent_addr, acc_last, req_mode};
            assign ok_c        = 1'b1;
            assign allow_c     = 3'b111;

            // R13
            open_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid |-> (rsp_grant && rsp_r && rsp_w && rsp_x));
        end
    endgenerate

    // Granted only when the rule allows it and no requested bit is missing.
    assign grant_c = ok_c && ((req_rwx & ~allow_c) == 3'b000);

    // Response register: one decision per valid request, all zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_deny  <= 1'b0;
            {rsp_x, rsp_w, rsp_r} <= 3'b000;
        end else if (req_valid) begin
            rsp_valid <= 1'b1;
            rsp_grant <= grant_c;
            rsp_deny  <= !grant_c;
            {rsp_x, rsp_w, rsp_r} <= allow_c;
        end else begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_deny  <= 1'b0;
            {rsp_x, rsp_w, rsp_r} <= 3'b000;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_deny && {rsp_x, rsp_w, rsp_r} == 3'b000));

    // R10
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant != rsp_deny));

    // R10
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rsp_grant) |-> (($past(req_rwx) & ~{rsp_x, rsp_w, rsp_r}) == 3'b000));

endmodule

// File: tb/tb_pmpc_checker.sv
// Bench: a behavioural reference model predicts every response cycle; the
// bench drives inputs on falling edges and compares on falling edges.
module tb_pmpc_checker;
    localparam int CLK_PERIOD = 10;
    localparam int NE  = 16;
    localparam int AW  = 32;
    localparam int SZW = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [AW-1:0]     req_addr;
    logic [SZW-1:0]    req_size;
    logic [2:0]        req_rwx;
    logic [1:0]        req_mode;
    logic [NE*8-1:0]   ent_cfg;
    logic [NE*30-1:0]  ent_addr;
    logic rsp_valid, rsp_grant, rsp_deny, rsp_r, rsp_w, rsp_x;
    logic o_valid, o_grant, o_deny, o_r, o_w, o_x;

    logic [7:0]  cfg_b [NE];
    logic [29:0] areg_b [NE];

    int checks = 0;
    int errors = 0;
    string cur_tag = "R2";
    string exp_tag = "R1";
    bit   exp_valid, exp_grant;
    bit [2:0] exp_perm;
    bit   exp_off_valid;
    bit   done = 0;
    int   cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the bench's entry arrays onto the configuration ports.
    always_comb begin
        for (int i = 0; i < NE; i++) begin
            ent_cfg[i*8 +: 8]   = cfg_b[i];
            ent_addr[i*30 +: 30] = areg_b[i];
        end
    end

    pmpc_checker #(.NE(NE), .AW(AW), .SZW(SZW), .PROT_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_rwx(req_rwx), .req_mode(req_mode),
        .ent_cfg(ent_cfg), .ent_addr(ent_addr), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_deny(rsp_deny), .rsp_r(rsp_r),
        .rsp_w(rsp_w), .rsp_x(rsp_x));

    pmpc_checker #(.NE(NE), .AW(AW), .SZW(SZW), .PROT_EN(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_rwx(req_rwx), .req_mode(req_mode),
        .ent_cfg(ent_cfg), .ent_addr(ent_addr), .rsp_valid(o_valid),
        .rsp_grant(o_grant), .rsp_deny(o_deny), .rsp_r(o_r),
        .rsp_w(o_w), .rsp_x(o_x));

    // Reference model written from the requirements with integer ranges.
    function automatic void model(input longint a, input int sz, input bit [2:0] rwx,
                                  input bit [1:0] md, output bit g, output bit [2:0] perm);
        longint first = a;
        longint last  = a + ((sz == 0) ? 1 : sz) - 1;
        bit decided = 0;
        longint prev = 0;
        g = 0; perm = 0;
        for (int i = 0; i < NE; i++) begin
            longint lo = 0, hi = -1, cur = longint'(areg_b[i]);
            bit en = 0;
            case (cfg_b[i][4:3])
                2'd1: begin lo = prev * 4; hi = cur * 4 - 1; en = (hi >= lo); end
                2'd2: begin lo = cur * 4; hi = lo + 3; en = 1; end
                2'd3: begin
                    int t = 0;
                    longint words;
                    while (t < 30 && areg_b[i][t]) t++;
                    words = longint'(1) << (t + 1);
                    lo = (cur / words) * words * 4;
                    hi = lo + words * 4 - 1;
                    if (hi > 64'hFFFF_FFFF) hi = 64'hFFFF_FFFF;
                    en = 1;
                end
                default: en = 0;
            endcase
            prev = cur;
            if (!decided && en && first <= hi && last >= lo) begin
                decided = 1;
                if (first >= lo && last <= hi) begin
                    perm = (md == 2'd3 && !cfg_b[i][7]) ? 3'b111 : cfg_b[i][2:0];
                    g = ((rwx & ~perm) == 3'b000);
                end
            end
        end
        if (!decided && md == 2'd3) begin
            g = 1; perm = 3'b111;
        end
    endfunction

    // Predict the response that the coming edge will register.
    always @(posedge clk) begin
        cycles++;
        exp_tag = cur_tag;
        if (!rst_n || !req_valid) begin
            exp_valid = 0; exp_grant = 0; exp_perm = 0; exp_off_valid = 0;
            if (!rst_n) exp_tag = "R1";
        end else begin
            exp_valid = 1; exp_off_valid = 1;
            model(longint'(req_addr), int'(req_size), req_rwx, req_mode, exp_grant, exp_perm);
        end
    end

    // Compare both instances with the prediction, every cycle.
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            checks++;
            if (rsp_valid !== exp_valid || rsp_grant !== (exp_valid && exp_grant) ||
                rsp_deny !== (exp_valid && !exp_grant) || {rsp_x, rsp_w, rsp_r} !== exp_perm) begin
                errors++;
                $display("FAIL %s t=%0t actual v=%b g=%b d=%b xwr=%b expected v=%b g=%b d=%b xwr=%b",
                         exp_tag, $time, rsp_valid, rsp_grant, rsp_deny, {rsp_x, rsp_w, rsp_r},
                         exp_valid, exp_valid && exp_grant, exp_valid && !exp_grant, exp_perm);
            end
            checks++;
            // R13: the unprotected variant grants everything
            if (o_valid !== exp_off_valid || o_grant !== exp_off_valid || o_deny !== 1'b0 ||
                {o_x, o_w, o_r} !== {3{exp_off_valid}}) begin
                errors++;
                $display("FAIL R13 actual v=%b g=%b d=%b xwr=%b expected v=%b g=%b d=0 xwr=%b",
                         o_valid, o_grant, o_deny, {o_x, o_w, o_r}, exp_off_valid,
                         exp_off_valid, {3{exp_off_valid}});
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (!done && cycles > 20000) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual cycles=%0d expected below 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic go(input logic [31:0] a, input int sz, input logic [2:0] rwx,
                      input logic [1:0] md, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = SZW'(sz);
        req_rwx   = rwx;
        req_mode  = md;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur_tag   = "R2";
            req_valid = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin cfg_b[i] = 8'h00; areg_b[i] = '0; end
        rst_n = 0; req_valid = 1; req_addr = 32'h100; req_size = 4; req_rwx = 3'b001; req_mode = 2'd3;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports with a request held high
        checks++;
        if ({rsp_valid, rsp_grant, rsp_deny, rsp_r, rsp_w, rsp_x} !== 6'b0) begin
            errors++;
            $display("FAIL R1 actual %b expected 000000",
                     {rsp_valid, rsp_grant, rsp_deny, rsp_r, rsp_w, rsp_x});
        end
        req_valid = 0;
        rst_n = 1;
        idle(2);

        // R11 / R5: all entries off
        areg_b[6] = 30'h3FFF_FFFF;
        go(32'h100, 4, 3'b001, 2'd0, "R11");
        go(32'h100, 4, 3'b010, 2'd3, "R11");
        go(32'h500, 4, 3'b100, 2'd1, "R5");
        idle(1);

        // R7 / R9 / R10: entry 0 four bytes at 0x100, read only
        @(negedge clk); cfg_b[0] = 8'h11; areg_b[0] = 30'h40;
        go(32'h100, 4, 3'b001, 2'd0, "R7");
        go(32'h100, 4, 3'b010, 2'd0, "R10");
        go(32'h104, 4, 3'b001, 2'd0, "R7");
        go(32'h103, 0, 3'b001, 2'd1, "R4");
        go(32'h103, 2, 3'b001, 2'd1, "R4");
        go(32'h100, 4, 3'b010, 2'd3, "R9");

        // R8: entry 1 power-of-two region 0x1000..0x1FFF read/write
        @(negedge clk); cfg_b[1] = 8'h1B; areg_b[1] = 30'h5FF;
        go(32'h1FFC, 4, 3'b010, 2'd0, "R8");
        go(32'h1000, 8, 3'b100, 2'd0, "R8");
        go(32'h1FFE, 4, 3'b001, 2'd0, "R12");
        go(32'h0FFE, 4, 3'b001, 2'd3, "R12");

        // R6: entry 2 top-of-range [0x17FC, 0x3000) execute
        @(negedge clk); cfg_b[2] = 8'h0C; areg_b[2] = 30'hC00;
        go(32'h2000, 4, 3'b100, 2'd0, "R6");
        go(32'h2FFE, 4, 3'b100, 2'd0, "R12");
        go(32'h3000, 4, 3'b100, 2'd0, "R6");

        // R3: entry 3 duplicates 0x100 with full rights; entry 0 wins
        @(negedge clk); cfg_b[3] = 8'h17; areg_b[3] = 30'h40;
        go(32'h100, 4, 3'b010, 2'd0, "R3");
        go(32'h100, 4, 3'b001, 2'd1, "R3");

        // R9: lock entry 0; machine mode now limited
        @(negedge clk); cfg_b[0] = 8'h91;
        go(32'h100, 4, 3'b010, 2'd3, "R9");
        go(32'h100, 4, 3'b001, 2'd3, "R9");

        // R12: partial cover of entry 4 blocks the covering entry 5
        @(negedge clk); cfg_b[4] = 8'h17; areg_b[4] = 30'h80; cfg_b[5] = 8'h1F; areg_b[5] = 30'h80;
        go(32'h202, 4, 3'b001, 2'd3, "R12");
        go(32'h204, 4, 3'b001, 2'd0, "R3");

        // R6: entry 0 as top-of-range from zero, and an empty range
        @(negedge clk); cfg_b[0] = 8'h09; areg_b[0] = 30'h20;
        go(32'h0, 4, 3'b001, 2'd0, "R6");
        go(32'h7C, 4, 3'b001, 2'd0, "R6");
        go(32'h7E, 4, 3'b001, 2'd0, "R12");
        @(negedge clk); cfg_b[7] = 8'h0F; areg_b[7] = 30'h10; cfg_b[6] = 8'h00; areg_b[6] = 30'h20;
        go(32'h50, 4, 3'b001, 2'd0, "R6");
        idle(2);

        // Mixed traffic with periodic reconfiguration.
        for (int n = 0; n < 400; n++) begin
            if (n % 25 == 0) begin
                @(negedge clk);
                for (int i = 0; i < NE; i++) begin
                    cfg_b[i]  = 8'($urandom);
                    areg_b[i] = 30'($urandom_range(0, 32'h1000));
                end
            end
            go($urandom_range(0, 32'h4400), $urandom_range(0, 15),
               3'b001 << $urandom_range(0, 2),
               ($urandom_range(0, 2) == 2) ? 2'd3 : 2'($urandom_range(0, 1)), "R10");
            if (n % 7 == 0) idle(1);
        end
        idle(3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule